// File: doc/BRIEF.md
# Capture-Mode Timer Channel

This block is a single measurement channel of a general-purpose timer. A 16-bit counter advances on each valid tick delivered by an upstream clock controller. Chosen edges of input A copy the running count into one of two capture registers, and a third register holds a compare value. From the captures, software can derive periods, pulse widths, duty cycle and phase. The channel can be restarted by several trigger sources. It collects sticky event flags that clear when the status word is read, and it drives one interrupt line through a writable mask.

Software reaches the channel through a simple word-addressed port: `bus_rd_i` or `bus_wr_i` with `bus_addr_i`. Read data is combinational. Word map: 0 command (write), 1 mode (read/write), 2 count (read), 3 capture A (read), 4 capture B (read), 5 compare C (read/write), 6 status (read), 7 mask set (write), 8 mask clear (write), 9 mask (read). Unmapped reads return 0. Mode fields: [1:0] external trigger edge, [2] external trigger source (0 input A, 1 input B), [3] compare-C trigger enable, [5:4] load-A edge, [7:6] load-B edge, [8] stop clock on B load, [9] disable clock on B load. Every edge field uses 0 none, 1 rising, 2 falling, 3 both.

Top module: `cap_timer`

## Requirements
- R1: The count advances by one on each cycle where `tick_i` is high and the clock is both enabled and started, and otherwise holds. The step from 0xFFFF to 0x0000 sets status bit 0.
- R2: A trigger does not change the count at once. The count becomes 0 on the next valid tick. A trigger starts the clock when the clock is enabled.
- R3: These are triggers: command bit 2 (software), a high `sync_i`, and a compare-C match while mode bit 3 is set.
- R4: The external trigger fires on the edge of the input selected by mode bit 2, as chosen by mode [1:0]. Code 0 never fires. Each firing sets status bit 7.
- R5: Capture A takes the count on the input-A edge chosen by mode [5:4]. Capture B takes the count on the input-A edge chosen by mode [7:6].
- R6: Loads alternate A, B, A, and so on. A loads only when no A load has happened since the last trigger or since the last B load. B loads only after an A load. A trigger restarts the order with A. A load of A sets status bit 5 and a load of B sets bit 6.
- R7: Loading a capture register whose previous value has not been read sets status bit 1, and the new value overwrites the old one. Reading the register clears its unread state.
- R8: A B load stops the clock when mode bit 8 is set. It disables the clock when mode bit 9 is set.
- R9: Command bit 0 enables the clock and command bit 1 disables it. Disable wins over enable. Status bit 16 shows the enable. While the clock is disabled, triggers do not start it and the count holds.
- R10: Status carries event flags in bits 0 to 7, the enable in bit 16, the input-A level in bit 17 and the input-B level in bit 18. Reading status clears bits 0 to 7. An event in the same cycle as the read leaves its flag set. After reset, status reads with bits 0 to 7 clear.
- R11: A write to mask set ORs 1s into the mask. A write to mask clear removes them. `irq_o` is high when any status bit 0 to 7 is set while its mask bit is also set.
- R12: A tick that makes the count equal compare C sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Count strobe from the clock controller |
| sync_i | input | 1 | Trigger pulse shared by all channels |
| in_a_i | input | 1 | Measured input A, synchronous |
| in_b_i | input | 1 | Measured input B, synchronous |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (enables read side effects) |
| bus_addr_i | input | 4 | Register word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the addressed word |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is the capture interlock. Landing a second A or B load on an unread register has to happen both right after a B load and right after a trigger, and it must fall in the right phase of the A/B order. Directed sequences toggle input A one edge per cycle, with single ticks in between, so every capture holds a distinct value. Read timing then decides whether overrun is expected. The wrap at 0xFFFF is reached by free-running the counter through its full range. A random phase then mixes edges, sync pulses, commands and reads against a bench reference model.

// File: rtl/cap_timer.sv
module cap_timer #(
  parameter int CW = 16,
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          sync_i,
  input  logic          in_a_i,
  input  logic          in_b_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o
);
  localparam int MW = 10;
  localparam int NF = 8;
  localparam logic [AW-1:0] A_CMD  = AW'(0);
  localparam logic [AW-1:0] A_MODE = AW'(1);
  localparam logic [AW-1:0] A_CNT  = AW'(2);
  localparam logic [AW-1:0] A_CAPA = AW'(3);
  localparam logic [AW-1:0] A_CAPB = AW'(4);
  localparam logic [AW-1:0] A_CMPC = AW'(5);
  localparam logic [AW-1:0] A_STAT = AW'(6);
  localparam logic [AW-1:0] A_ISET = AW'(7);
  localparam logic [AW-1:0] A_ICLR = AW'(8);
  localparam logic [AW-1:0] A_IMSK = AW'(9);
  localparam logic [CW-1:0] CMAX   = '1;

  logic [CW-1:0] cnt, ra, rb, rc;
  logic [MW-1:0] mode;
  logic [NF-1:0] flags, mask, ev;
  logic clk_en, running, pend, a_done, a_unr, b_unr, a_q, b_q;

  function automatic logic edge_hit(input logic [1:0] sel, input logic cur, input logic prev);
    return (sel[0] & cur & ~prev) | (sel[1] & ~cur & prev);
  endfunction

  wire cmd_wr = bus_wr_i && bus_addr_i == A_CMD;
  wire rd_st  = bus_rd_i && bus_addr_i == A_STAT;
  wire rd_a   = bus_rd_i && bus_addr_i == A_CAPA;
  wire rd_b   = bus_rd_i && bus_addr_i == A_CAPB;

  wire src    = mode[2] ? in_b_i : in_a_i;
  wire src_q  = mode[2] ? b_q : a_q;
  wire ext_ev = edge_hit(mode[1:0], src, src_q);

  wire           cnt_en  = tick_i & clk_en & running;
  wire [CW-1:0]  cnt_nxt = pend ? '0 : cnt + CW'(1);
  wire           cmp_ev  = cnt_en && cnt_nxt == rc;
  wire           ovf_ev  = cnt_en && !pend && cnt == CMAX;
  wire           trig    = (cmd_wr & bus_wdata_i[2]) | sync_i | ext_ev | (cmp_ev & mode[3]);

  wire ld_a   = edge_hit(mode[5:4], in_a_i, a_q) & ~a_done;
  wire ld_b   = edge_hit(mode[7:6], in_a_i, a_q) & a_done;
  wire ovr_ev = (ld_a & a_unr) | (ld_b & b_unr);

  wire en_nxt = (cmd_wr & bus_wdata_i[1]) | (ld_b & mode[9]) ? 1'b0 :
                (cmd_wr & bus_wdata_i[0]) ? 1'b1 : clk_en;

  assign ev    = {ext_ev, ld_b, ld_a, cmp_ev, 2'b00, ovr_ev, ovf_ev};
  assign irq_o = |(flags & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; ra <= '0; rb <= '0; rc <= '0;
      mode <= '0; flags <= '0; mask <= '0;
      clk_en <= 1'b0; running <= 1'b0; pend <= 1'b0;
      a_done <= 1'b0; a_unr <= 1'b0; b_unr <= 1'b0;
      a_q <= 1'b0; b_q <= 1'b0;
    end else begin
      a_q <= in_a_i;
      b_q <= in_b_i;
      if (cnt_en) cnt <= cnt_nxt;
      pend   <= trig | (pend & ~cnt_en);
      clk_en <= en_nxt;
      if (trig && en_nxt)        running <= 1'b1;
      else if (ld_b && mode[8])  running <= 1'b0;
      if (trig)      a_done <= 1'b0;
      else if (ld_a) a_done <= 1'b1;
      else if (ld_b) a_done <= 1'b0;
      if (ld_a) ra <= cnt;
      if (ld_b) rb <= cnt;
      a_unr <= ld_a | (a_unr & ~rd_a);
      b_unr <= ld_b | (b_unr & ~rd_b);
      flags <= (rd_st ? '0 : flags) | ev;
      if (bus_wr_i && bus_addr_i == A_MODE) mode <= bus_wdata_i[MW-1:0];
      if (bus_wr_i && bus_addr_i == A_CMPC) rc <= bus_wdata_i[CW-1:0];
      if (bus_wr_i && bus_addr_i == A_ISET) mask <= mask | bus_wdata_i[NF-1:0];
      if (bus_wr_i && bus_addr_i == A_ICLR) mask <= mask & ~bus_wdata_i[NF-1:0];
    end
  end

  always_comb begin
    case (bus_addr_i)
      A_MODE:  bus_rdata_o = DW'(mode);
      A_CNT:   bus_rdata_o = DW'(cnt);
      A_CAPA:  bus_rdata_o = DW'(ra);
      A_CAPB:  bus_rdata_o = DW'(rb);
      A_CMPC:  bus_rdata_o = DW'(rc);
      A_STAT:  bus_rdata_o = {{(DW-19){1'b0}}, in_b_i, in_a_i, clk_en, 8'd0, flags};
      A_IMSK:  bus_rdata_o = DW'(mask);
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cap_timer_chk.sv
module cap_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] cnt,
  input logic          cnt_en,
  input logic          pend,
  input logic          ld_a,
  input logic          ld_b,
  input logic          trig,
  input logic          stop_b,
  input logic          running,
  input logic          rd_st,
  input logic [7:0]    flags
);
  logic [CW-1:0] cnt_inc;
  assign cnt_inc = cnt + CW'(1);

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !cnt_en |=> $stable(cnt)); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) cnt_en && !pend |=> cnt == $past(cnt_inc)); // R1
  AST_TRIG_ZERO: assert property (@(posedge clk) disable iff (!rst_n) cnt_en && pend |=> cnt == '0); // R2
  AST_LOAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n) ld_a |-> !ld_b); // R6
  AST_B_STOP: assert property (@(posedge clk) disable iff (!rst_n) ld_b && stop_b && !trig |=> !running); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !rd_st |=> (flags & $past(flags)) == $past(flags)); // R10
endmodule

bind cap_timer cap_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_en(cnt_en), .pend(pend),
  .ld_a(ld_a), .ld_b(ld_b), .trig(trig), .stop_b(mode[8]), .running(running),
  .rd_st(rd_st), .flags(flags)
);

// File: tb/cap_timer_tb.sv
`timescale 1ns/1ps
module cap_timer_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, sync = 0, in_a = 0, in_b = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq;
  logic pa = 0, pb = 0, psy = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cap_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .sync_i(sync), .in_a_i(in_a), .in_b_i(in_b),
    .bus_wr_i(bus_wr), .bus_rd_i(bus_rd), .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata),
    .bus_rdata_o(bus_rdata), .irq_o(irq)
  );

  // reference model built from the requirements
  logic [15:0] m_cnt, m_ra, m_rb, m_rc, nc;
  logic [9:0]  m_mode;
  logic [7:0]  m_flags, m_mask;
  logic m_en, m_run, m_pend, m_adone, m_aunr, m_bunr, m_aq, m_bq;
  logic go, trg, la, lb, e_ext, e_cmp, e_ovf, e_ovr, cmd, s_cur, s_prev;

  function automatic logic edge_f(input logic [1:0] sel, input logic cur, input logic prev);
    if (sel == 2'd1) return cur && !prev;
    if (sel == 2'd2) return !cur && prev;
    if (sel == 2'd3) return cur != prev;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_ra = 0; m_rb = 0; m_rc = 0; m_mode = 0; m_flags = 0; m_mask = 0;
      m_en = 0; m_run = 0; m_pend = 0; m_adone = 0; m_aunr = 0; m_bunr = 0; m_aq = 0; m_bq = 0;
    end else begin
      s_cur  = m_mode[2] ? in_b : in_a;
      s_prev = m_mode[2] ? m_bq : m_aq;
      e_ext  = edge_f(m_mode[1:0], s_cur, s_prev);
      go     = tick && m_en && m_run;
      nc     = m_pend ? 16'd0 : m_cnt + 16'd1;
      e_cmp  = go && nc == m_rc;
      e_ovf  = go && !m_pend && m_cnt == 16'hFFFF;
      cmd    = bus_wr && bus_addr == 4'd0;
      trg    = (cmd && bus_wdata[2]) || sync || e_ext || (e_cmp && m_mode[3]);
      la     = edge_f(m_mode[5:4], in_a, m_aq) && !m_adone;
      lb     = edge_f(m_mode[7:6], in_a, m_aq) && m_adone;
      e_ovr  = (la && m_aunr) || (lb && m_bunr);
      if (bus_rd && bus_addr == 4'd6) m_flags = 0;
      m_flags = m_flags | {e_ext, lb, la, e_cmp, 2'b00, e_ovr, e_ovf};
      if (la) m_ra = m_cnt;
      if (lb) m_rb = m_cnt;
      m_aunr = la || (m_aunr && !(bus_rd && bus_addr == 4'd3));
      m_bunr = lb || (m_bunr && !(bus_rd && bus_addr == 4'd4));
      if ((cmd && bus_wdata[1]) || (lb && m_mode[9])) m_en = 0;
      else if (cmd && bus_wdata[0]) m_en = 1;
      if (trg && m_en) m_run = 1;
      else if (lb && m_mode[8]) m_run = 0;
      if (go) m_cnt = nc;
      m_pend = trg || (m_pend && !go);
      if (trg) m_adone = 0; else if (la) m_adone = 1; else if (lb) m_adone = 0;
      if (bus_wr && bus_addr == 4'd1) m_mode = bus_wdata[9:0];
      if (bus_wr && bus_addr == 4'd5) m_rc = bus_wdata[15:0];
      if (bus_wr && bus_addr == 4'd7) m_mask = m_mask | bus_wdata[7:0];
      if (bus_wr && bus_addr == 4'd8) m_mask = m_mask & ~bus_wdata[7:0];
      m_aq = in_a; m_bq = in_b;
    end
  end

  function automatic logic [31:0] m_read(input logic [3:0] ad);
    case (ad)
      4'd1: return {22'd0, m_mode};
      4'd2: return {16'd0, m_cnt};
      4'd3: return {16'd0, m_ra};
      4'd4: return {16'd0, m_rb};
      4'd5: return {16'd0, m_rc};
      4'd6: return {13'd0, in_b, in_a, m_en, 8'd0, m_flags};
      4'd9: return {24'd0, m_mask};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] ad);
    case (ad)
      4'd2: return "R1 count";
      4'd3, 4'd4: return "R5 capture";
      4'd6: return "R10 status";
      4'd9: return "R11 mask";
      4'd1, 4'd5: return "R3 config";
      default: return "R10 unmapped";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic op(input logic w, input logic r, input logic [3:0] ad, input logic [31:0] d,
                    input logic tk, output logic [31:0] q);
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = ad; bus_wdata = d; tick = tk;
    in_a = pa; in_b = pb; sync = psy;
    #2;
    q = bus_rdata;
    if (r) chk(tag_of(ad), bus_rdata, m_read(ad));
    chk("R11 irq", {31'd0, irq}, {31'd0, |(m_flags & m_mask)});
  endtask

  task automatic idle(input int n, input logic tk);
    logic [31:0] q;
    repeat (n) op(1'b0, 1'b0, 4'd0, 32'd0, tk, q);
  endtask

  task automatic wr(input logic [3:0] ad, input logic [31:0] d);
    logic [31:0] q;
    op(1'b1, 1'b0, ad, d, 1'b0, q);
  endtask

  task automatic expect_rd(input string tag, input logic [3:0] ad, input logic [31:0] msk,
                           input logic [31:0] exp);
    logic [31:0] q;
    op(1'b0, 1'b1, ad, 32'd0, 1'b0, q);
    chk(tag, q & msk, exp);
  endtask

  initial begin
    #1500000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q, q0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd("R10 reset status", 4'd6, 32'hFFFFFFFF, 32'd0);
    expect_rd("R1 reset count", 4'd2, 32'hFFFFFFFF, 32'd0);
    // R9 enable alone does not start counting
    wr(4'd0, 32'd1);
    expect_rd("R9 enable bit", 4'd6, 32'h00010000, 32'h00010000);
    idle(3, 1'b1);
    expect_rd("R1 not started", 4'd2, 32'hFFFF, 32'd0);
    // R2 trigger timing
    wr(4'd0, 32'd4);
    idle(5, 1'b1);
    expect_rd("R1 count", 4'd2, 32'hFFFF, 32'd4);
    wr(4'd0, 32'd4);
    expect_rd("R2 no immediate clear", 4'd2, 32'hFFFF, 32'd4);
    idle(1, 1'b1);
    expect_rd("R2 zero on tick", 4'd2, 32'hFFFF, 32'd0);
    idle(3, 1'b1);
    expect_rd("R1 count after trig", 4'd2, 32'hFFFF, 32'd3);
    // R5 capture on edges
    wr(4'd1, 32'h090);
    pa = 1; idle(1, 1'b0);
    idle(2, 1'b1);
    pa = 0; idle(1, 1'b0);
    expect_rd("R5 capture A", 4'd3, 32'hFFFF, 32'd3);
    expect_rd("R5 capture B", 4'd4, 32'hFFFF, 32'd5);
    expect_rd("R6 load flags", 4'd6, 32'h00010060, 32'h00010060);
    expect_rd("R10 read clears", 4'd6, 32'hFF, 32'd0);
    // R7 overrun
    pa = 1; idle(1, 1'b0);
    idle(1, 1'b1);
    pa = 0; idle(1, 1'b0);
    expect_rd("R7 no overrun", 4'd6, 32'h2, 32'd0);
    idle(1, 1'b1);
    pa = 1; idle(1, 1'b0);
    expect_rd("R7 overrun set", 4'd6, 32'h2, 32'h2);
    expect_rd("R7 overwritten", 4'd3, 32'hFFFF, 32'd7);
    // R6 alternation with identical edges
    wr(4'd1, 32'h050);
    pa = 0; idle(1, 1'b0);
    idle(1, 1'b1);
    pa = 1; idle(1, 1'b0);
    pa = 0; idle(1, 1'b0);
    idle(1, 1'b1);
    pa = 1; idle(1, 1'b0);
    pa = 0; idle(1, 1'b0);
    idle(1, 1'b1);
    pa = 1; idle(1, 1'b0);
    expect_rd("R6 alternate A", 4'd3, 32'hFFFF, 32'd9);
    expect_rd("R6 alternate B", 4'd4, 32'hFFFF, 32'd10);
    pa = 0; idle(1, 1'b0);
    pa = 1; idle(1, 1'b0);
    wr(4'd0, 32'd4);
    idle(1, 1'b1);
    pa = 0; idle(1, 1'b0);
    pa = 1; idle(1, 1'b0);
    expect_rd("R6 trigger restarts with A", 4'd3, 32'hFFFF, 32'd0);
    expect_rd("R6 B untouched", 4'd4, 32'hFFFF, 32'd10);
    // R8 stop on B load
    wr(4'd1, 32'h190);
    wr(4'd0, 32'd4);
    idle(2, 1'b1);
    pa = 0; idle(1, 1'b0);
    pa = 1; idle(1, 1'b0);
    idle(1, 1'b1);
    pa = 0; idle(1, 1'b0);
    idle(3, 1'b1);
    expect_rd("R8 stopped", 4'd2, 32'hFFFF, 32'd2);
    expect_rd("R8 still enabled", 4'd6, 32'h00010000, 32'h00010000);
    wr(4'd0, 32'd4);
    idle(2, 1'b1);
    expect_rd("R8 restart", 4'd2, 32'hFFFF, 32'd1);
    // R8 disable on B load
    wr(4'd1, 32'h290);
    pa = 1; idle(1, 1'b0);
    pa = 0; idle(1, 1'b0);
    expect_rd("R8 disabled", 4'd6, 32'h00010000, 32'd0);
    wr(4'd0, 32'd4);
    idle(3, 1'b1);
    expect_rd("R9 trigger ignored when disabled", 4'd2, 32'hFFFF, 32'd1);
    wr(4'd0, 32'd1);
    idle(1, 1'b1);
    expect_rd("R9 re-enable", 4'd2, 32'hFFFF, 32'd0);
    wr(4'd0, 32'd3);
    expect_rd("R9 disable wins", 4'd6, 32'h00010000, 32'd0);
    wr(4'd0, 32'd1);
    // R4 external trigger on rising input B
    wr(4'd1, 32'h005);
    idle(3, 1'b1);
    op(1'b0, 1'b1, 4'd2, 32'd0, 1'b0, q0);
    pb = 1; idle(1, 1'b0);
    expect_rd("R4 no immediate clear", 4'd2, 32'hFFFF, q0 & 32'hFFFF);
    idle(1, 1'b1);
    expect_rd("R4 ext trigger zero", 4'd2, 32'hFFFF, 32'd0);
    expect_rd("R4 ext flag", 4'd6, 32'h00040080, 32'h00040080);
    pb = 0; idle(1, 1'b0);
    idle(2, 1'b1);
    expect_rd("R4 falling ignored", 4'd2, 32'hFFFF, 32'd2);
    // R10 event wins over simultaneous read
    pb = 1; op(1'b0, 1'b1, 4'd6, 32'd0, 1'b0, q);
    expect_rd("R10 event wins", 4'd6, 32'h80, 32'h80);
    pb = 0;
    // R3 sync trigger
    idle(2, 1'b1);
    psy = 1; idle(1, 1'b0);
    psy = 0; idle(1, 1'b1);
    expect_rd("R3 sync trigger", 4'd2, 32'hFFFF, 32'd0);
    // R3 and R12 compare trigger
    wr(4'd5, 32'd3);
    wr(4'd1, 32'h008);
    wr(4'd0, 32'd4);
    idle(10, 1'b1);
    expect_rd("R3 compare period", 4'd2, 32'hFFFF, 32'd1);
    expect_rd("R12 compare flag", 4'd6, 32'h10, 32'h10);
    // R11 mask
    idle(4, 1'b1);
    wr(4'd7, 32'h10);
    idle(1, 1'b0);
    chk("R11 irq raised", {31'd0, irq}, 32'd1);
    expect_rd("R11 mask read", 4'd9, 32'hFF, 32'h10);
    wr(4'd8, 32'h10);
    idle(1, 1'b0);
    chk("R11 irq masked", {31'd0, irq}, 32'd0);
    // R1 wrap
    wr(4'd1, 32'h000);
    wr(4'd5, 32'h1234);
    wr(4'd0, 32'd4);
    op(1'b0, 1'b1, 4'd6, 32'd0, 1'b0, q);
    idle(65536, 1'b1);
    expect_rd("R1 at max", 4'd2, 32'hFFFF, 32'hFFFF);
    expect_rd("R1 no overflow yet", 4'd6, 32'h1, 32'd0);
    idle(1, 1'b1);
    expect_rd("R1 wrapped", 4'd2, 32'hFFFF, 32'd0);
    expect_rd("R1 overflow flag", 4'd6, 32'h1, 32'h1);
    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic w, r, tk;
      logic [3:0] ad;
      logic [31:0] d;
      if ($urandom % 6 == 0) pa = ~pa;
      if ($urandom % 8 == 0) pb = ~pb;
      psy = ($urandom % 50 == 0);
      tk = ($urandom % 3 != 0);
      r = ($urandom % 3 == 0);
      w = !r && ($urandom % 20 == 0);
      ad = 4'($urandom % 11);
      d = $urandom;
      if (w) begin
        case ($urandom % 5)
          0: begin ad = 4'd0; d = d % 8; end
          1: begin ad = 4'd1; d = d & 32'h3FF; end
          2: begin ad = 4'd5; d = d % 16; end
          3: ad = 4'd7;
          default: ad = 4'd8;
        endcase
        if (ad == 4'd0 && d[1] && $urandom % 2 == 0) d[1] = 1'b0;
      end
      op(w, r, ad, d, tk, q);
    end
    psy = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule